// File: doc/BRIEF.md
# Bitmap Video Window Generator

This block produces the pixel stream for a digital video encoder. A 54 MHz reference clock drives all of its logic. A toggle register divides that clock by two to make a 27 MHz pixel clock, which is also driven out to the encoder. A pixel-enable strobe advances the raster counters once per pixel period. The counters run over a full line and frame. A bitmap window sits inside them, and its first line, first pixel and line count come from run-time inputs, so the picture can be centred on the screen. An NTSC frame has fewer lines than a PAL frame, so it needs a smaller height. Every pixel outside the window is painted a fixed green border colour.

Each bitmap line is 256 source pixels wide and is read from an external line buffer through a combinational index/data pair. The window is always twice the source width. With the stretch input set, each source pixel is shown on two adjacent output pixels, so the bitmap fills the whole window. With stretch clear, only the left half of the window carries bitmap data and the right half is black. At the first pixel of the line before every window line, the block raises a fetch request and gives the window-relative line number, so the line buffer can be filled one line ahead of display. Colour, sync and fetch outputs are registered together with one pixel of latency.

Top module: `bitmap_window_gen`

## Requirements
- R1: `pix_clk` is low in reset and inverts on every `clk54` rising edge after reset. Every output except `src_index` changes only on the edge at which `pix_clk` falls.
- R2: The horizontal count runs from 0 to LINE_LEN-1 and the line count from 0 to FRAME_LINES-1. Both wrap to 0, and the first pixel after reset is pixel 0 of line 0.
- R3: The colour for pixel h of line v appears on `pix_data` one pixel period after that position is scanned. At the same time `hsync` is 1 exactly when h < HSYNC_LEN, and `vsync` is 1 exactly when v < VSYNC_LINES.
- R4: A pixel is in the window when win_top <= v < win_top+win_height and win_left <= h < win_left+2*SRC_W. Every pixel outside the window is driven 16'h07E0 (green, 5-6-5 RGB).
- R5: With `stretch`=1, a window pixel with relative offset r = h-win_left shows source pixel r>>1. Each source pixel therefore appears on two adjacent output pixels.
- R6: With `stretch`=0, a window pixel with r < SRC_W shows source pixel r, and a window pixel with r >= SRC_W is driven 16'h0000.
- R7: `fetch_req` is 1 for exactly the pixel period of pixel 0 on each line whose next line (line FRAME_LINES-1 wraps to 0) is in the window. During that period `fetch_line` equals the next line minus win_top.
- R8: While `rst_n` is low at a `clk54` edge, `pix_clk`, `pix_data`, `hsync`, `vsync`, `fetch_req` and `fetch_line` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk54 | input | 1 | 54 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stretch | input | 1 | 1: each source pixel shown twice; 0: left half only |
| win_top | input | VW | First window line |
| win_left | input | HW | First window pixel in a line |
| win_height | input | VW | Number of window lines |
| src_pixel | input | 16 | Line-buffer data for `src_index` (combinational return) |
| src_index | output | SIW | Source pixel index within the current line |
| pix_clk | output | 1 | Pixel clock to the encoder (half of clk54) |
| pix_data | output | 16 | Registered 5-6-5 RGB pixel |
| hsync | output | 1 | Line sync, active high, aligned with `pix_data` |
| vsync | output | 1 | Frame sync, active high, aligned with `pix_data` |
| fetch_req | output | 1 | Request to fill the line buffer for the next window line |
| fetch_line | output | VW | Window-relative line number to fetch |

## Verification
The embedded assertions check on every cycle the rules that hold for any window setting. The pixel clock alternates. The horizontal count stays in range and wraps after its last value. Colour does not move between pixel enables. A fetch request or a rising frame sync always falls on a line-sync pixel. Only the bench's scenarios can show the values that depend on the window geometry. These are the border colour at each window edge, the doubled source index in stretch mode, the black right half when stretch is off, and the fetch issued in the last line of a frame for a window that starts at line 0. The bench scans four whole frames with different positions, heights and stretch settings, one of which runs off the right end of the line.

// File: rtl/bwg_pkg.sv
// Package bwg_pkg
// Shared pixel type and fixed colours for the bitmap window generator.
// Assumes 5-6-5 RGB packing in a 16-bit word.
package bwg_pkg;
    typedef logic [15:0] rgb565_t;
    localparam rgb565_t BORDER_GREEN = 16'h07E0;
    localparam rgb565_t FILL_BLACK   = 16'h0000;
endpackage

// File: rtl/bwg_pixclk_div.sv
// Module bwg_pixclk_div
// Divides the reference clock by two. pix_clk is the divided clock sent out
// to the encoder. pix_ce is high in the reference cycle that ends with
// pix_clk falling, and all pixel logic advances on that edge.
// Assumes a synchronous active-low reset. pix_clk is low after reset.
module bwg_pixclk_div (
    input  logic clk,
    input  logic rst_n,
    output logic pix_clk,
    output logic pix_ce
);
    // Toggle register forming the half-rate pixel clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_clk <= 1'b0;
        else        pix_clk <= ~pix_clk;
    end

    assign pix_ce = pix_clk;

    // R1
    pclk_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_clk |=> !pix_clk);
endmodule

// File: rtl/bwg_raster_count.sv
// Module bwg_raster_count
// Horizontal and vertical raster counters, advanced once per pixel enable.
// It also gives the line number that follows the current one, wrapping at
// the end of the frame, which the fetch logic uses.
// Assumes LINE_LEN >= 2 and FRAME_LINES >= 2.
module bwg_raster_count #(
    parameter int LINE_LEN    = 858,
    parameter int FRAME_LINES = 525,
    localparam int HW = $clog2(LINE_LEN),
    localparam int VW = $clog2(FRAME_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic [VW-1:0] vcnt_next
);
    localparam logic [HW-1:0] H_LAST = HW'(LINE_LEN - 1);
    localparam logic [VW-1:0] V_LAST = VW'(FRAME_LINES - 1);

    logic line_end;

    assign line_end  = (hcnt == H_LAST);
    assign vcnt_next = (vcnt == V_LAST) ? '0 : vcnt + 1'b1;

    // Pixel counter within a line.
    always_ff @(posedge clk) begin
        if (!rst_n)       hcnt <= '0;
        else if (ce)      hcnt <= line_end ? '0 : hcnt + 1'b1;
    end

    // Line counter within a frame, stepped at the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n)                vcnt <= '0;
        else if (ce && line_end)   vcnt <= vcnt_next;
    end

    // R2
    hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(hcnt) < LINE_LEN);
    // R2
    vcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(vcnt) < FRAME_LINES);
    // R2
    hcnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && hcnt == H_LAST) |=> hcnt == '0);
endmodule

// File: rtl/bwg_window_map.sv
// Module bwg_window_map
// Combinational window decode. It decides whether the scanned position lies
// inside the bitmap window, forms the source pixel index (halved in stretch
// mode) and selects the colour: border, source data or black fill. It also
// decides whether the next line is a window line that needs a fetch.
// Assumes SRC_W is a power of two. The window is 2*SRC_W pixels wide.
module bwg_window_map
    import bwg_pkg::*;
#(
    parameter int SRC_W = 256,
    parameter int HW    = 10,
    parameter int VW    = 10,
    localparam int SIW  = $clog2(SRC_W),
    localparam int WIN_W = 2 * SRC_W
) (
    input  logic [HW-1:0]  hcnt,
    input  logic [VW-1:0]  vcnt,
    input  logic [VW-1:0]  vcnt_next,
    input  logic           stretch,
    input  logic [VW-1:0]  win_top,
    input  logic [HW-1:0]  win_left,
    input  logic [VW-1:0]  win_height,
    input  rgb565_t        src_pixel,
    output logic [SIW-1:0] src_index,
    output rgb565_t        color,
    output logic           fetch_hit,
    output logic [VW-1:0]  fetch_rel
);
    logic [31:0] h32, l32, v32, vn32, t32, b32, rel32;
    logic        in_h, in_v, in_v_next, in_src;

    // Widen operands so the window end never overflows the counter width.
    always_comb begin
        h32  = 32'(hcnt);
        l32  = 32'(win_left);
        v32  = 32'(vcnt);
        vn32 = 32'(vcnt_next);
        t32  = 32'(win_top);
        b32  = 32'(win_top) + 32'(win_height);
        rel32 = h32 - l32;
    end

    // Window membership of the current pixel and of the next line.
    always_comb begin
        in_h      = (h32 >= l32) && (h32 < l32 + WIN_W);
        in_v      = (v32 >= t32) && (v32 < b32);
        in_v_next = (vn32 >= t32) && (vn32 < b32);
        in_src    = stretch || (rel32 < SRC_W);
    end

    // Source index: the relative offset, halved when stretching.
    always_comb begin
        if (in_h) src_index = SIW'(stretch ? (rel32 >> 1) : rel32);
        else      src_index = '0;
    end

    // Colour selection for the current position.
    always_comb begin
        if (!(in_h && in_v)) color = BORDER_GREEN;
        else if (in_src)     color = src_pixel;
        else                 color = FILL_BLACK;
    end

    // Fetch decision at the first pixel of the line before a window line.
    always_comb begin
        fetch_hit = (hcnt == '0) && in_v_next;
        fetch_rel = vcnt_next - win_top;
    end
endmodule

// File: rtl/bitmap_window_gen.sv
// Module bitmap_window_gen
// Top of the bitmap window generator. It divides the reference clock into the
// pixel clock, counts the raster, decodes the window and registers colour,
// syncs and fetch request together on the pixel enable, so all of them carry
// the same one-pixel latency.
// Assumes the line buffer returns src_pixel combinationally for src_index,
// and that the window inputs change only between frames for a clean picture.
module bitmap_window_gen
    import bwg_pkg::*;
#(
    parameter int SRC_W       = 256,
    parameter int LINE_LEN    = 858,
    parameter int FRAME_LINES = 525,
    parameter int HSYNC_LEN   = 64,
    parameter int VSYNC_LINES = 6,
    localparam int HW  = $clog2(LINE_LEN),
    localparam int VW  = $clog2(FRAME_LINES),
    localparam int SIW = $clog2(SRC_W)
) (
    input  logic           clk54,
    input  logic           rst_n,
    input  logic           stretch,
    input  logic [VW-1:0]  win_top,
    input  logic [HW-1:0]  win_left,
    input  logic [VW-1:0]  win_height,
    input  logic [15:0]    src_pixel,
    output logic [SIW-1:0] src_index,
    output logic           pix_clk,
    output logic [15:0]    pix_data,
    output logic           hsync,
    output logic           vsync,
    output logic           fetch_req,
    output logic [VW-1:0]  fetch_line
);
    logic          pix_ce;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt, vcnt_next;
    rgb565_t       color;
    logic          fetch_hit;
    logic [VW-1:0] fetch_rel;

    bwg_pixclk_div u_div (
        .clk     (clk54),
        .rst_n   (rst_n),
        .pix_clk (pix_clk),
        .pix_ce  (pix_ce)
    );

    bwg_raster_count #(
        .LINE_LEN    (LINE_LEN),
        .FRAME_LINES (FRAME_LINES)
    ) u_cnt (
        .clk       (clk54),
        .rst_n     (rst_n),
        .ce        (pix_ce),
        .hcnt      (hcnt),
        .vcnt      (vcnt),
        .vcnt_next (vcnt_next)
    );

    bwg_window_map #(
        .SRC_W (SRC_W),
        .HW    (HW),
        .VW    (VW)
    ) u_map (
        .hcnt       (hcnt),
        .vcnt       (vcnt),
        .vcnt_next  (vcnt_next),
        .stretch    (stretch),
        .win_top    (win_top),
        .win_left   (win_left),
        .win_height (win_height),
        .src_pixel  (src_pixel),
        .src_index  (src_index),
        .color      (color),
        .fetch_hit  (fetch_hit),
        .fetch_rel  (fetch_rel)
    );

    // Output stage: colour, syncs and fetch registered on the pixel enable.
    always_ff @(posedge clk54) begin
        if (!rst_n) begin
            pix_data   <= '0;
            hsync      <= 1'b0;
            vsync      <= 1'b0;
            fetch_req  <= 1'b0;
            fetch_line <= '0;
        end else if (pix_ce) begin
            pix_data   <= color;
            hsync      <= (32'(hcnt) < HSYNC_LEN);
            vsync      <= (32'(vcnt) < VSYNC_LINES);
            fetch_req  <= fetch_hit;
            fetch_line <= fetch_hit ? fetch_rel : '0;
        end
    end

    // R1
    pix_hold_chk: assert property (@(posedge clk54) disable iff (!rst_n)
        !pix_ce |=> $stable(pix_data) && $stable(hsync) && $stable(fetch_req));
    // R7
    fetch_on_sync_chk: assert property (@(posedge clk54) disable iff (!rst_n)
        fetch_req |-> hsync);
    // R3
    vsync_start_chk: assert property (@(posedge clk54) disable iff (!rst_n)
        $rose(vsync) |-> hsync);
endmodule

// File: tb/bitmap_window_gen_test.sv
module bitmap_window_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int SW    = 8;
    localparam int LINE  = 32;
    localparam int FRAME = 12;
    localparam int HSL   = 4;
    localparam int VSL   = 2;
    localparam int HW    = $clog2(LINE);
    localparam int VW    = $clog2(FRAME);
    localparam int SIW   = $clog2(SW);

    logic           clk54 = 1'b0;
    logic           rst_n = 1'b0;
    logic           stretch = 1'b0;
    logic [VW-1:0]  win_top = '0;
    logic [HW-1:0]  win_left = '0;
    logic [VW-1:0]  win_height = '0;
    logic [15:0]    src_pixel;
    logic [SIW-1:0] src_index;
    logic           pix_clk;
    logic [15:0]    pix_data;
    logic           hsync, vsync, fetch_req;
    logic [VW-1:0]  fetch_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        int          h;
        int          v;
        logic [15:0] pix;
        logic        hs, vs, fr;
        logic [VW-1:0] fl;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk54 = ~clk54;

    // Line buffer model: each source pixel carries its own index.
    assign src_pixel = 16'hA500 + 16'(src_index);

    bitmap_window_gen #(
        .SRC_W(SW), .LINE_LEN(LINE), .FRAME_LINES(FRAME),
        .HSYNC_LEN(HSL), .VSYNC_LINES(VSL)
    ) uut (
        .clk54(clk54), .rst_n(rst_n), .stretch(stretch),
        .win_top(win_top), .win_left(win_left), .win_height(win_height),
        .src_pixel(src_pixel), .src_index(src_index), .pix_clk(pix_clk),
        .pix_data(pix_data), .hsync(hsync), .vsync(vsync),
        .fetch_req(fetch_req), .fetch_line(fetch_line)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic bit line_in(input int v);
        return v >= int'(win_top) && v < int'(win_top) + int'(win_height);
    endfunction

    // Driver: expectation for raster position (h,v) from the requirements.
    task automatic push_expected(input int h, input int v);
        exp_t e;
        int   rel, nv;
        bit   inh;
        e.h = h; e.v = v;
        rel = h - int'(win_left);
        inh = h >= int'(win_left) && rel < 2 * SW;
        if (!(inh && line_in(v))) begin
            e.pix = 16'h07E0; e.tag = "R4 border";
        end else if (stretch) begin
            e.pix = 16'hA500 + 16'(rel >> 1); e.tag = "R5 stretch";
        end else if (rel < SW) begin
            e.pix = 16'hA500 + 16'(rel); e.tag = "R6 direct";
        end else begin
            e.pix = 16'h0000; e.tag = "R6 black";
        end
        e.hs = (h < HSL);
        e.vs = (v < VSL);
        nv = (v == FRAME - 1) ? 0 : v + 1;
        e.fr = (h == 0) && line_in(nv);
        e.fl = e.fr ? VW'(nv - int'(win_top)) : '0;
        sb.push_back(e);
    endtask

    logic [15:0] last_pix = '0;

    // Monitor: one pixel period; mid-period hold check, then pop and compare.
    task automatic monitor_pixel();
        exp_t e;
        @(posedge clk54); @(negedge clk54);
        check("R1 pix_clk high", int'(pix_clk), 1);
        check("R1 colour held mid-pixel", int'(pix_data), int'(last_pix));
        @(posedge clk54); @(negedge clk54);
        e = sb.pop_front();
        check("R1 pix_clk low", int'(pix_clk), 0);
        check($sformatf("%s h=%0d v=%0d", e.tag, e.h, e.v), int'(pix_data), int'(e.pix));
        check($sformatf("R2 R3 hsync h=%0d", e.h), int'(hsync), int'(e.hs));
        check($sformatf("R2 R3 vsync v=%0d", e.v), int'(vsync), int'(e.vs));
        check($sformatf("R7 fetch_req h=%0d v=%0d", e.h, e.v), int'(fetch_req), int'(e.fr));
        if (e.fr) check("R7 fetch_line", int'(fetch_line), int'(e.fl));
        last_pix = pix_data;
    endtask

    task automatic run_frame(input bit st, input int top, input int left, input int hgt);
        stretch = st;
        win_top = VW'(top); win_left = HW'(left); win_height = VW'(hgt);
        for (int v = 0; v < FRAME; v++)
            for (int h = 0; h < LINE; h++) begin
                push_expected(h, v);
                monitor_pixel();
            end
    endtask

    initial begin
        stretch = 1'b1; win_top = 4'd2; win_left = 5'd3; win_height = 4'd4;
        repeat (4) @(negedge clk54);
        // R8: reset state
        check("R8 pix_clk", int'(pix_clk), 0);
        check("R8 pix_data", int'(pix_data), 0);
        check("R8 hsync", int'(hsync), 0);
        check("R8 vsync", int'(vsync), 0);
        check("R8 fetch_req", int'(fetch_req), 0);
        check("R8 fetch_line", int'(fetch_line), 0);
        rst_n = 1'b1;
        run_frame(1'b1, 2, 3, 4);    // stretched, centred small window
        run_frame(1'b0, 2, 3, 4);    // unstretched, black right half
        run_frame(1'b1, 0, 14, 12);  // window from line 0: wrap fetch
        run_frame(1'b0, 5, 20, 7);   // window runs past line end
        if (sb.size() != 0) check("R3 scoreboard drained", sb.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk54);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule